// File: doc/BRIEF.md
# Rank Clustering Reorder Unit with Read Promotion

This unit takes a snapshot of the commands held back in a memory controller's reorder queue. Each command carries a target rank, a read/write flag and an address. The unit rewrites the snapshot into an output buffer so that all commands for one rank sit together as a contiguous set. The sets are ordered by the slot in which each rank first appears in the queue. Inside a set, reads are lifted ahead of writes, so that reads leave the per-rank FIFO command queue first. A read stays behind an older write of the same rank to the same address, and so no read-after-write order is broken.

A pass starts with a one-cycle `start_i` pulse. The unit then consumes one queue slot per clock. It places each command by insertion at a per-rank marker and moves every later set back by one slot. When the pass ends, `done_o` pulses and three per-rank counters are valid: total commands, reads and writes. Downstream logic uses these counters to decide which ranks have pending reads. The buffer and the counters hold their values until the next pass starts.

Top module: `rank_cluster_reorder`

## Requirements
- R1: While reset is low and after its release, `busy_o` and `done_o` are 0, every count output is 0 and every output slot is 0.
- R2: In the output, commands for one rank form one contiguous set. The sets are ordered by the slot in which each rank first appears among the first `count_i` input slots (slot 0 is the oldest).
- R3: Inside a set, the promoted reads keep their input order among themselves. The remaining commands (writes and held-back reads) also keep their input order among themselves.
- R4: Inside a set, every promoted read comes before every write and every held-back read.
- R5: A read is held back (not promoted) when an older write in the input has the same rank and the same address. A matching write for another rank does not hold a read back.
- R6: For each rank r, `tot_o[r*PW +: PW]`, `rd_cnt_o[r*PW +: PW]` and `wr_cnt_o[r*PW +: PW]` give the number of commands, reads and writes for that rank. The total equals reads plus writes, and a rank with no command reports 0 in all three.
- R7: With N = `count_i` at least 1, `busy_o` is high during the pass. `done_o` rises on the Nth rising edge after the edge that samples `start_i` and stays high for exactly one cycle.
- R8: With `count_i` = 0, `done_o` rises on the edge that samples `start_i`. All counts and all output slots are then 0.
- R9: A `start_i` pulse while `busy_o` is high is ignored: the running pass, its inputs and its timing are unchanged.
- R10: Output slots at index `count_i` and above are 0, whatever the input slots at those positions hold. Input slot s uses `rank_i[s*RANK_W +: RANK_W]`, `is_rd_i[s]` (1 = read) and `addr_i[s*ADDR_W +: ADDR_W]`. The outputs use the same layout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse that starts a pass on the current snapshot |
| count_i | input | PW | Number of valid slots in the snapshot (at most DEPTH) |
| rank_i | input | DEPTH*RANK_W | Target rank of each snapshot slot |
| is_rd_i | input | DEPTH | 1 = read, 0 = write, one bit per slot |
| addr_i | input | DEPTH*ADDR_W | Address of each snapshot slot |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle pulse when the outputs are valid |
| rank_o | output | DEPTH*RANK_W | Rank of each reordered slot |
| is_rd_o | output | DEPTH | Read flag of each reordered slot |
| addr_o | output | DEPTH*ADDR_W | Address of each reordered slot |
| tot_o | output | RANKS*PW | Commands per rank |
| rd_cnt_o | output | RANKS*PW | Reads per rank |
| wr_cnt_o | output | RANKS*PW | Writes per rank |

## Verification
The snapshots used in the tests each isolate one behaviour:
- A mixed queue with three ranks and one idle rank separates set ordering by first appearance from ordering by rank number.
- A single-rank queue with write/read pairs to the same address shows whether held-back reads stay behind their writes while an unrelated read still moves forward.
- An all-read queue and a fully interleaved queue, in which every rank first appears in descending rank order, show whether insertion shifts every later set correctly.
- A queue with a matching write on a different rank shows that the hazard test also compares ranks.
- A one-entry queue with garbage in the unused slots, an empty queue and a second start pulse during a pass cover the boundaries.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } rc_phase_e;
endpackage

// File: rtl/rc_hazard.sv
`timescale 1ns/1ps
// Selects the slot under processing and flags a read that must not be
// promoted because an older write of the same rank targets its address.
module rc_hazard #(
  parameter int DEPTH  = 8,
  parameter int RANK_W = 2,
  parameter int ADDR_W = 8,
  parameter int PW     = 4
) (
  input  logic [DEPTH*RANK_W-1:0] rank_v,
  input  logic [DEPTH-1:0]        rd_v,
  input  logic [DEPTH*ADDR_W-1:0] addr_v,
  input  logic [PW-1:0]           idx,
  output logic [RANK_W-1:0]       cur_rank,
  output logic                    cur_rd,
  output logic [ADDR_W-1:0]       cur_addr,
  output logic                    pinned
);
  logic older_wr;

  always_comb begin
    cur_rank = '0;
    cur_rd   = 1'b0;
    cur_addr = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (k == int'(idx)) begin
        cur_rank = rank_v[k*RANK_W +: RANK_W];
        cur_rd   = rd_v[k];
        cur_addr = addr_v[k*ADDR_W +: ADDR_W];
      end
    end
  end

  always_comb begin
    older_wr = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((k < int'(idx)) && !rd_v[k] &&
          (rank_v[k*RANK_W +: RANK_W] == cur_rank) &&
          (addr_v[k*ADDR_W +: ADDR_W] == cur_addr))
        older_wr = 1'b1;
    end
    pinned = cur_rd && older_wr;
  end
endmodule

// File: rtl/rc_rank_slot.sv
`timescale 1ns/1ps
// Per-rank bookkeeping: first-seen order, end of promoted reads,
// end of the set, and read/write counters.
module rc_rank_slot #(
  parameter int PW     = 4,
  parameter int RANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              hit,
  input  logic              promote,
  input  logic              is_rd,
  input  logic [PW-1:0]     idx,
  input  logic [RANK_W-1:0] cur_order,
  input  logic [RANK_W-1:0] new_order,
  output logic              seen_o,
  output logic [RANK_W-1:0] order_o,
  output logic [PW-1:0]     rd_mark_o,
  output logic [PW-1:0]     set_mark_o,
  output logic [PW-1:0]     nrd_o,
  output logic [PW-1:0]     nwr_o
);
  logic              seen_q, seen_d;
  logic [RANK_W-1:0] order_q, order_d;
  logic [PW-1:0]     rdm_q, rdm_d, setm_q, setm_d, nrd_q, nrd_d, nwr_q, nwr_d;
  logic [PW-1:0]     rd_base, set_base;

  always_comb begin
    seen_d   = seen_q;
    order_d  = order_q;
    rdm_d    = rdm_q;
    setm_d   = setm_q;
    nrd_d    = nrd_q;
    nwr_d    = nwr_q;
    rd_base  = seen_q ? rdm_q  : idx;
    set_base = seen_q ? setm_q : idx;
    if (clear) begin
      seen_d  = 1'b0;
      order_d = '0;
      rdm_d   = '0;
      setm_d  = '0;
      nrd_d   = '0;
      nwr_d   = '0;
    end else if (step && hit) begin
      if (!seen_q) begin
        seen_d  = 1'b1;
        order_d = new_order;
      end
      setm_d = set_base + 1'b1;
      rdm_d  = rd_base + PW'(promote);
      nrd_d  = nrd_q + PW'(is_rd);
      nwr_d  = nwr_q + PW'(!is_rd);
    end else if (step && seen_q && (order_q > cur_order)) begin
      setm_d = setm_q + 1'b1;
      rdm_d  = rdm_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      order_q <= '0;
      rdm_q   <= '0;
      setm_q  <= '0;
      nrd_q   <= '0;
      nwr_q   <= '0;
    end else if (clear || step) begin
      seen_q  <= seen_d;
      order_q <= order_d;
      rdm_q   <= rdm_d;
      setm_q  <= setm_d;
      nrd_q   <= nrd_d;
      nwr_q   <= nwr_d;
    end
  end

  assign seen_o     = seen_q;
  assign order_o    = order_q;
  assign rd_mark_o  = rdm_q;
  assign set_mark_o = setm_q;
  assign nrd_o      = nrd_q;
  assign nwr_o      = nwr_q;

  // R4: the promoted-read region never extends past the end of its set
  p_rd_within_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdm_q <= setm_q) else $error("promoted region past set end");

  // R6: a rank that was never seen carries no counts
  p_unseen_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (nrd_q == '0) && (nwr_q == '0)) else $error("counts on unseen rank");
endmodule

// File: rtl/rc_insert_buf.sv
`timescale 1ns/1ps
// Output buffer with insert-and-shift: the new entry lands at ins_pos and
// slots ins_pos..fill-1 move one slot later.
module rc_insert_buf #(
  parameter int DEPTH  = 8,
  parameter int RANK_W = 2,
  parameter int ADDR_W = 8,
  parameter int PW     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    ins_en,
  input  logic [PW-1:0]           ins_pos,
  input  logic [PW-1:0]           fill,
  input  logic [RANK_W-1:0]       new_rank,
  input  logic                    new_rd,
  input  logic [ADDR_W-1:0]       new_addr,
  output logic [DEPTH*RANK_W-1:0] rank_o,
  output logic [DEPTH-1:0]        rd_o,
  output logic [DEPTH*ADDR_W-1:0] addr_o
);
  logic [RANK_W-1:0] rk_q [DEPTH];
  logic              rd_q [DEPTH];
  logic [ADDR_W-1:0] ad_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    localparam int PREV = (s == 0) ? 0 : s - 1;
    logic [RANK_W-1:0] rk_d;
    logic              rd_d;
    logic [ADDR_W-1:0] ad_d;

    always_comb begin
      rk_d = rk_q[s];
      rd_d = rd_q[s];
      ad_d = ad_q[s];
      if (clear) begin
        rk_d = '0;
        rd_d = 1'b0;
        ad_d = '0;
      end else if (s == int'(ins_pos)) begin
        rk_d = new_rank;
        rd_d = new_rd;
        ad_d = new_addr;
      end else if ((s > int'(ins_pos)) && (s <= int'(fill)) && (s != 0)) begin
        rk_d = rk_q[PREV];
        rd_d = rd_q[PREV];
        ad_d = ad_q[PREV];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rk_q[s] <= '0;
        rd_q[s] <= 1'b0;
        ad_q[s] <= '0;
      end else if (clear || ins_en) begin
        rk_q[s] <= rk_d;
        rd_q[s] <= rd_d;
        ad_q[s] <= ad_d;
      end
    end

    assign rank_o[s*RANK_W +: RANK_W] = rk_q[s];
    assign rd_o[s]                    = rd_q[s];
    assign addr_o[s*ADDR_W +: ADDR_W] = ad_q[s];
  end

  // R2: an insertion never lands beyond the filled region
  p_pos_in_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (ins_pos <= fill)) else $error("insert beyond fill");
endmodule

// File: rtl/rank_cluster_reorder.sv
`timescale 1ns/1ps
module rank_cluster_reorder
  import rc_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int RANKS  = 4,
  parameter  int ADDR_W = 8,
  localparam int RANK_W = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int PW     = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [PW-1:0]           count_i,
  input  logic [DEPTH*RANK_W-1:0] rank_i,
  input  logic [DEPTH-1:0]        is_rd_i,
  input  logic [DEPTH*ADDR_W-1:0] addr_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [DEPTH*RANK_W-1:0] rank_o,
  output logic [DEPTH-1:0]        is_rd_o,
  output logic [DEPTH*ADDR_W-1:0] addr_o,
  output logic [RANKS*PW-1:0]     tot_o,
  output logic [RANKS*PW-1:0]     rd_cnt_o,
  output logic [RANKS*PW-1:0]     wr_cnt_o
);
  rc_phase_e               phase_q, phase_d;
  logic [PW-1:0]           idx_q, idx_d, cnt_q, cnt_d, cnt_clamp;
  logic                    done_q, done_d;
  logic [RANK_W:0]         seen_cnt_q, seen_cnt_d;
  logic [DEPTH*RANK_W-1:0] snap_rank_q;
  logic [DEPTH-1:0]        snap_rd_q;
  logic [DEPTH*ADDR_W-1:0] snap_addr_q;
  logic                    accept, step, last;

  logic [RANK_W-1:0] cur_rank;
  logic              cur_rd, pinned, promote;
  logic [ADDR_W-1:0] cur_addr;

  logic              seen_v [RANKS];
  logic [RANK_W-1:0] order_a [RANKS];
  logic [PW-1:0]     rdm_a [RANKS], setm_a [RANKS], nrd_a [RANKS], nwr_a [RANKS];
  logic              cur_seen;
  logic [RANK_W-1:0] cur_order;
  logic [PW-1:0]     rdm_sel, setm_sel, ins_pos;

  assign accept    = (phase_q == PH_IDLE) && start_i;
  assign step      = (phase_q == PH_RUN);
  assign last      = step && (idx_q == cnt_q - 1'b1);
  assign cnt_clamp = (count_i > PW'(DEPTH)) ? PW'(DEPTH) : count_i;

  always_comb begin
    phase_d    = phase_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    seen_cnt_d = seen_cnt_q;
    done_d     = 1'b0;
    if (accept) begin
      cnt_d      = cnt_clamp;
      idx_d      = '0;
      seen_cnt_d = '0;
      phase_d    = (cnt_clamp != '0) ? PH_RUN : PH_IDLE;
      done_d     = (cnt_clamp == '0);
    end else if (step) begin
      idx_d = idx_q + 1'b1;
      if (!cur_seen) seen_cnt_d = seen_cnt_q + 1'b1;
      if (last) begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      idx_q      <= '0;
      cnt_q      <= '0;
      seen_cnt_q <= '0;
      done_q     <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      idx_q      <= idx_d;
      cnt_q      <= cnt_d;
      seen_cnt_q <= seen_cnt_d;
      done_q     <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_rank_q <= '0;
      snap_rd_q   <= '0;
      snap_addr_q <= '0;
    end else if (accept) begin
      snap_rank_q <= rank_i;
      snap_rd_q   <= is_rd_i;
      snap_addr_q <= addr_i;
    end
  end

  rc_hazard #(.DEPTH(DEPTH), .RANK_W(RANK_W), .ADDR_W(ADDR_W), .PW(PW)) hazard_i (
    .rank_v(snap_rank_q), .rd_v(snap_rd_q), .addr_v(snap_addr_q), .idx(idx_q),
    .cur_rank(cur_rank), .cur_rd(cur_rd), .cur_addr(cur_addr), .pinned(pinned)
  );

  assign promote = cur_rd && !pinned;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    rc_rank_slot #(.PW(PW), .RANK_W(RANK_W)) slot_i (
      .clk(clk), .rst_n(rst_n), .clear(accept), .step(step),
      .hit(cur_rank == RANK_W'(r)), .promote(promote), .is_rd(cur_rd),
      .idx(idx_q), .cur_order(cur_order), .new_order(seen_cnt_q[RANK_W-1:0]),
      .seen_o(seen_v[r]), .order_o(order_a[r]), .rd_mark_o(rdm_a[r]),
      .set_mark_o(setm_a[r]), .nrd_o(nrd_a[r]), .nwr_o(nwr_a[r])
    );
    assign tot_o[r*PW +: PW]    = nrd_a[r] + nwr_a[r];
    assign rd_cnt_o[r*PW +: PW] = nrd_a[r];
    assign wr_cnt_o[r*PW +: PW] = nwr_a[r];
  end

  always_comb begin
    cur_seen = 1'b0;
    cur_order = seen_cnt_q[RANK_W-1:0];
    rdm_sel  = idx_q;
    setm_sel = idx_q;
    for (int r = 0; r < RANKS; r++) begin
      if ((cur_rank == RANK_W'(r)) && seen_v[r]) begin
        cur_seen  = 1'b1;
        cur_order = order_a[r];
        rdm_sel   = rdm_a[r];
        setm_sel  = setm_a[r];
      end
    end
    ins_pos = promote ? rdm_sel : setm_sel;
  end

  rc_insert_buf #(.DEPTH(DEPTH), .RANK_W(RANK_W), .ADDR_W(ADDR_W), .PW(PW)) buf_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .ins_en(step), .ins_pos(ins_pos),
    .fill(idx_q), .new_rank(cur_rank), .new_rd(cur_rd), .new_addr(cur_addr),
    .rank_o(rank_o), .rd_o(is_rd_o), .addr_o(addr_o)
  );

  assign busy_o = step;
  assign done_o = done_q;

  int tot_sum;
  int seen_sum;
  always_comb begin
    tot_sum  = 0;
    seen_sum = 0;
    for (int r = 0; r < RANKS; r++) begin
      tot_sum  = tot_sum + int'(nrd_a[r]) + int'(nwr_a[r]);
      seen_sum = seen_sum + int'(seen_v[r]);
    end
  end

  // R6: per-rank counts account for every snapshot entry at completion
  p_sum_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (tot_sum == int'(cnt_q))) else $error("count sum mismatch");

  // R7: done lasts one cycle unless a new empty pass is accepted
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> !done_q) else $error("done longer than one cycle");

  // R7: the slot index stays inside the snapshot while busy
  p_busy_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (idx_q < cnt_q)) else $error("index past snapshot");

  // R2: number of first-seen ranks matches the order allocator
  p_seen_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_sum == int'(seen_cnt_q)) else $error("seen count mismatch");

  // R9: a start during a pass leaves the snapshot unchanged
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && start_i) |=> $stable(snap_rank_q) && $stable(cnt_q)) else $error("start accepted while busy");
endmodule

// File: tb/rank_cluster_reorder_tb_top.sv
`timescale 1ns/1ps
module rank_cluster_reorder_tb_top;
  localparam int DEPTH = 8, RANKS = 4, RANK_W = 2, ADDR_W = 8, PW = 4;
  localparam int NV = 6;

  // Slot encoding in the table: 16 bits per slot, slot 0 in the low bits.
  // bit 12 = read, bits 9:8 = rank, bits 7:0 = address.
  localparam logic [127:0] VDATA [NV] = '{
    128'h0014_0013_0221_1012_0130_0011_1220_0010,
    128'h0000_0000_0000_1106_0106_1106_1105_0105,
    128'h0000_0000_1006_1105_1004_1303_1102_1301,
    128'h1377_1366_1355_1344_1333_1322_1311_0240,
    128'h1047_0146_1245_0344_0043_1142_0241_1340,
    128'h0000_0000_0000_0000_0000_1107_0109_0007
  };
  localparam int VCNT [NV] = '{8, 5, 6, 1, 8, 3};
  localparam string VTAG [NV] = '{
    "R2 R3 R4 mixed sets",
    "R5 R3 same-address hold",
    "R2 R3 all reads",
    "R10 single entry",
    "R2 R4 interleaved full",
    "R5 other-rank address"
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst_n, start_i;
  logic [PW-1:0]           count_i;
  logic [DEPTH*RANK_W-1:0] rank_i;
  logic [DEPTH-1:0]        is_rd_i;
  logic [DEPTH*ADDR_W-1:0] addr_i;
  logic                    busy_o, done_o;
  logic [DEPTH*RANK_W-1:0] rank_o;
  logic [DEPTH-1:0]        is_rd_o;
  logic [DEPTH*ADDR_W-1:0] addr_o;
  logic [RANKS*PW-1:0]     tot_o, rd_cnt_o, wr_cnt_o;

  rank_cluster_reorder #(.DEPTH(DEPTH), .RANKS(RANKS), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .rank_i(rank_i), .is_rd_i(is_rd_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .rank_o(rank_o), .is_rd_o(is_rd_o),
    .addr_o(addr_o), .tot_o(tot_o), .rd_cnt_o(rd_cnt_o), .wr_cnt_o(wr_cnt_o)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic bit is_held(input logic [127:0] v, input int s);
    logic [15:0] cs = v[s*16 +: 16];
    for (int k = 0; k < s; k++) begin
      logic [15:0] ks = v[k*16 +: 16];
      if (!ks[12] && (ks[9:8] == cs[9:8]) && (ks[7:0] == cs[7:0])) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [127:0] model_order(input logic [127:0] v, input int n);
    logic [127:0] out = '0;
    int firsts [RANKS];
    bit seen [RANKS];
    int nset = 0;
    int pos = 0;
    for (int r = 0; r < RANKS; r++) seen[r] = 1'b0;
    for (int s = 0; s < n; s++) begin
      int rk = int'(v[s*16+8 +: 2]);
      if (!seen[rk]) begin
        seen[rk] = 1'b1;
        firsts[nset] = rk;
        nset++;
      end
    end
    for (int o = 0; o < nset; o++) begin
      for (int pass = 0; pass < 2; pass++) begin
        for (int s = 0; s < n; s++) begin
          logic [15:0] sl = v[s*16 +: 16];
          bit front = sl[12] && !is_held(v, s);
          if ((int'(sl[9:8]) == firsts[o]) && (front == (pass == 0))) begin
            out[pos*16 +: 16] = {3'b000, sl[12], 2'b00, sl[9:8], sl[7:0]};
            pos++;
          end
        end
      end
    end
    return out;
  endfunction

  function automatic logic [127:0] model_counts(input logic [127:0] v, input int n);
    logic [15:0] t = '0, rc = '0, wc = '0;
    for (int s = 0; s < n; s++) begin
      int rk = int'(v[s*16+8 +: 2]);
      t[rk*4 +: 4] = t[rk*4 +: 4] + 4'd1;
      if (v[s*16+12]) rc[rk*4 +: 4] = rc[rk*4 +: 4] + 4'd1;
      else            wc[rk*4 +: 4] = wc[rk*4 +: 4] + 4'd1;
    end
    return {80'd0, t, rc, wc};
  endfunction

  function automatic logic [127:0] dut_order();
    logic [127:0] out = '0;
    for (int s = 0; s < DEPTH; s++)
      out[s*16 +: 16] = {3'b000, is_rd_o[s], 2'b00, rank_o[s*2 +: 2], addr_o[s*8 +: 8]};
    return out;
  endfunction

  function automatic logic [127:0] dut_counts();
    return {80'd0, tot_o, rd_cnt_o, wr_cnt_o};
  endfunction

  task automatic drive(input logic [127:0] v, input int n);
    count_i = PW'(n);
    for (int s = 0; s < DEPTH; s++) begin
      rank_i[s*2 +: 2] = v[s*16+8 +: 2];
      is_rd_i[s]       = v[s*16+12];
      addr_i[s*8 +: 8] = v[s*16 +: 8];
    end
  endtask

  task automatic run_pass(input logic [127:0] v, input int n, input bit inject,
                          output int lat);
    @(negedge clk);
    drive(v, n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 50) begin
      if (inject && lat == 1) begin
        drive(128'h1311_1311_1311_1311_1311_1311_1311_1311, 2);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
  endtask

  initial begin
    int lat;
    rst_n   = 1'b0;
    start_i = 1'b0;
    count_i = '0;
    rank_i  = '0;
    is_rd_i = '0;
    addr_i  = '0;
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && dut_counts() == '0 && dut_order() == '0,
          "R1 reset state", dut_counts() | dut_order(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && dut_counts() == '0, "R1 after release",
          {busy_o, done_o}, '0);

    for (int i = 0; i < NV; i++) begin
      run_pass(VDATA[i], VCNT[i], 1'b0, lat);
      check(dut_order() == model_order(VDATA[i], VCNT[i]),
            {VTAG[i], " order"}, dut_order(), model_order(VDATA[i], VCNT[i]));
      check(dut_counts() == model_counts(VDATA[i], VCNT[i]),
            {VTAG[i], " R6 counts"}, dut_counts(), model_counts(VDATA[i], VCNT[i]));
      check(lat == VCNT[i], {VTAG[i], " R7 latency"}, 128'(lat), 128'(VCNT[i]));
      @(negedge clk);
      check(!done_o, {VTAG[i], " R7 done width"}, 128'(done_o), '0);
    end

    // R8: empty snapshot
    run_pass(VDATA[0], 0, 1'b0, lat);
    check(lat == 0, "R8 empty latency", 128'(lat), '0);
    check(dut_counts() == '0 && dut_order() == '0, "R8 empty outputs",
          dut_counts() | dut_order(), '0);

    // R9: start during a pass is ignored
    run_pass(VDATA[1], VCNT[1], 1'b1, lat);
    check(dut_order() == model_order(VDATA[1], VCNT[1]), "R9 order after extra start",
          dut_order(), model_order(VDATA[1], VCNT[1]));
    check(lat == VCNT[1], "R9 latency after extra start", 128'(lat), 128'(VCNT[1]));
    check(dut_counts() == model_counts(VDATA[1], VCNT[1]), "R9 counts after extra start",
          dut_counts(), model_counts(VDATA[1], VCNT[1]));

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule